// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date as eight byte-wide registers in binary-coded decimal. It counts hundredths of a second, then seconds, minutes, hours, weekday, day of month, month and two-digit year. A one-cycle tick input marks each elapsed hundredth of a second. Each tick that is allowed to count moves the whole carry chain forward in the same clock cycle. A byte-wide write port loads any one register. A separate combinational read port returns any register by index. A serial access engine can step through the registers in index order, from 0 to 7, using these two ports.

The hours register also holds the display mode. When its top bit is set the hour runs from 12 through 11 and carries an afternoon flag. Otherwise the hour runs from 00 to 23. The weekday register also holds two control bits. One stops the timebase and the other masks an external abort request. Both control bits are exposed on dedicated outputs. Every register slot that holds no field reads as zero.

The design is purely synchronous. It has no state machine: one register bank, one next-value network built from small rollover cells, and one write-override path.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the registers, by index, hold 0x00, 0x00, 0x00, 0x00, 0x31, 0x01, 0x01, 0x00. The time is 00:00:00.00 in 24-hour mode, the weekday is 1 with both control bits set, and the date is 01/01 of year 00.
- R2: On each counted tick, register 0 (hundredths) advances in BCD from 00 to 99 and wraps to 00. The wrap advances register 1 (seconds, 00 to 59). The seconds wrap advances register 2 (minutes, 00 to 59). The minutes wrap advances the hour.
- R3: With register 3 bit 7 clear (24-hour mode), bits 5:4 hold the tens of hours and bits 3:0 the units. The hour runs from 00 to 23. Going from 23 to 00 advances the weekday and the date.
- R4: With register 3 bit 7 set (12-hour mode), bit 4 and bits 3:0 hold the hour as 12, 01, …, 11, and bit 5 is the afternoon flag. Going from 11 to 12 inverts bit 5. Going from 11 to 12 with bit 5 set (midnight) advances the weekday and the date. Going from 12 to 01 keeps bit 5.
- R5: Register 4 bits 2:0 hold the weekday, 1 to 7. A day advance goes from 7 back to 1 and leaves bits 5:4 unchanged.
- R6: Register 5 (date) wraps to 01 after the last day of the month and then advances register 6 (month). April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by four, with year 00 counted as leap, and 28 days otherwise. Every other month has 31 days. Month 12 wraps to 01 and advances register 7 (year). Year 99 wraps to 00.
- R7: While register 4 bit 5 is 1, ticks change no register and `osc_run_o` is 0. While it is 0, ticks count and `osc_run_o` is 1.
- R8: `abort_allow_o` is 1 exactly when register 4 bit 4 is 0.
- R9: Writes keep only the field bits and drop the rest. The bits dropped, and read as zero, are register 1 bit 7, register 2 bit 7, register 3 bit 6, register 4 bits 7, 6 and 3, register 5 bits 7:6, and register 6 bits 7:5.
- R10: A write in the same cycle as a tick loads the addressed register, and the tick is dropped for every register. Counting resumes from the loaded values on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per hundredth of a second |
| wr_en_i | input | 1 | Load the register selected by `wr_idx_i` |
| wr_idx_i | input | 3 | Register index for a load |
| wr_data_i | input | 8 | Byte to load; bits outside the field are dropped |
| rd_idx_i | input | 3 | Register index for a read |
| rd_data_o | output | 8 | Combinational contents of the selected register |
| osc_run_o | output | 1 | 1 while the timebase is allowed to count |
| abort_allow_o | output | 1 | 1 while an external abort request is to be honoured |

## Verification
A wrong carry, or a wrong month length, shows up in the register that receives it at the first tick that crosses the boundary. It can be seen at the read port half a cycle after that clock edge. Every later tick then compares against a shifted date, so the error never clears. Mode and control faults, such as a lost afternoon flag, a stuck stop bit or a dropped write, show up at the read port or the two control outputs one cycle after the stimulus that should have changed them. For that reason the reference model is compared against all eight registers and both outputs after every clock.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;
    localparam int NREG  = 8;
    localparam int IDX_W = $clog2(NREG);
    localparam int BYTE_W = 8;

    localparam int IDX_CENTI = 0;
    localparam int IDX_SEC   = 1;
    localparam int IDX_MIN   = 2;
    localparam int IDX_HOUR  = 3;
    localparam int IDX_WDAY  = 4;
    localparam int IDX_DATE  = 5;
    localparam int IDX_MONTH = 6;
    localparam int IDX_YEAR  = 7;

    localparam int HOUR_MODE_BIT = 7;
    localparam int HOUR_PM_BIT   = 5;
    localparam int WDAY_STOP_BIT = 4 + 1;
    localparam int WDAY_RSTEN_BIT = 4;

    // Bits that hold a field; all others are dropped on write.
    function automatic logic [BYTE_W-1:0] keep_mask(input int idx);
        case (idx)
            IDX_SEC, IDX_MIN: keep_mask = 8'h7F;
            IDX_HOUR:         keep_mask = 8'hBF;
            IDX_WDAY:         keep_mask = 8'h37;
            IDX_DATE:         keep_mask = 8'h3F;
            IDX_MONTH:        keep_mask = 8'h1F;
            default:          keep_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reset_val(input int idx);
        case (idx)
            IDX_WDAY:             reset_val = 8'h31;
            IDX_DATE, IDX_MONTH:  reset_val = 8'h01;
            default:              reset_val = 8'h00;
        endcase
    endfunction

    // Two-digit BCD increment.
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/tk_bcd_wrap.sv
`timescale 1ns/1ps
// One BCD rollover cell: counts up to top_i, then returns to LOW.
module tk_bcd_wrap
    import tk_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOW = 8'h00
) (
    input  logic [BYTE_W-1:0] val_i,
    input  logic [BYTE_W-1:0] top_i,
    input  logic              inc_i,
    output logic [BYTE_W-1:0] val_o,
    output logic              carry_o
);
    always_comb begin
        val_o   = val_i;
        carry_o = 1'b0;
        if (inc_i) begin
            if (val_i >= top_i) begin
                val_o   = LOW;
                carry_o = 1'b1;
            end else begin
                val_o = bcd_inc(val_i);
            end
        end
    end
endmodule

// File: rtl/tk_month_len.sv
`timescale 1ns/1ps
// Last day of the month in BCD, from BCD month and two-digit BCD year.
module tk_month_len
    import tk_pkg::*;
(
    input  logic [BYTE_W-1:0] month_i,
    input  logic [BYTE_W-1:0] year_i,
    output logic [BYTE_W-1:0] last_o
);
    logic leap;

    // Divisible by four: even tens need units 0/4/8, odd tens need 2/6.
    always_comb begin
        if (year_i[4]) leap = (year_i[3:0] == 4'd2) || (year_i[3:0] == 4'd6);
        else           leap = (year_i[3:0] == 4'd0) || (year_i[3:0] == 4'd4) ||
                              (year_i[3:0] == 4'd8);
    end

    always_comb begin
        unique case (month_i)
            8'h02:                      last_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/tk_hour_step.sv
`timescale 1ns/1ps
// Hour advance for both display modes, with day carry.
module tk_hour_step
    import tk_pkg::*;
(
    input  logic [BYTE_W-1:0] hour_i,
    input  logic              inc_i,
    output logic [BYTE_W-1:0] hour_o,
    output logic              day_o
);
    logic [BYTE_W-1:0] h24, h12, h12_inc;
    logic              pm;

    assign h24     = {2'b00, hour_i[5:0]};
    assign h12     = {3'b000, hour_i[4:0]};
    assign pm      = hour_i[HOUR_PM_BIT];
    assign h12_inc = bcd_inc(h12);

    always_comb begin
        hour_o = hour_i;
        day_o  = 1'b0;
        if (inc_i) begin
            if (!hour_i[HOUR_MODE_BIT]) begin
                if (h24 >= 8'h23) begin
                    hour_o = 8'h00;
                    day_o  = 1'b1;
                end else begin
                    hour_o = bcd_inc(h24);
                end
            end else if (h12 == 8'h11) begin
                hour_o = {1'b1, 1'b0, ~pm, 5'h12};
                day_o  = pm;
            end else if (h12 >= 8'h12) begin
                hour_o = {1'b1, 1'b0, pm, 5'h01};
            end else begin
                hour_o = {1'b1, 1'b0, pm, h12_inc[4:0]};
            end
        end
    end
endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              osc_run_o,
    output logic              abort_allow_o
);
    logic [NREG-1:0][BYTE_W-1:0] reg_q, reg_d;
    logic [BYTE_W-1:0] cen_n, sec_n, min_n, hour_n, date_n, mon_n, year_n, last_day;
    logic              adv, c_cen, c_sec, c_min, c_day, c_date, c_mon;
    logic [2:0]        dow_n;

    assign osc_run_o     = ~reg_q[IDX_WDAY][WDAY_STOP_BIT];
    assign abort_allow_o = ~reg_q[IDX_WDAY][WDAY_RSTEN_BIT];
    assign rd_data_o     = reg_q[rd_idx_i];
    assign adv           = tick_i & ~wr_en_i & osc_run_o;

    tk_bcd_wrap #(.LOW(8'h00)) u_cen (.val_i(reg_q[IDX_CENTI]), .top_i(8'h99),
        .inc_i(adv), .val_o(cen_n), .carry_o(c_cen));
    tk_bcd_wrap #(.LOW(8'h00)) u_sec (.val_i(reg_q[IDX_SEC]), .top_i(8'h59),
        .inc_i(c_cen), .val_o(sec_n), .carry_o(c_sec));
    tk_bcd_wrap #(.LOW(8'h00)) u_min (.val_i(reg_q[IDX_MIN]), .top_i(8'h59),
        .inc_i(c_sec), .val_o(min_n), .carry_o(c_min));
    tk_hour_step u_hour (.hour_i(reg_q[IDX_HOUR]), .inc_i(c_min),
        .hour_o(hour_n), .day_o(c_day));
    tk_month_len u_mlen (.month_i(reg_q[IDX_MONTH]), .year_i(reg_q[IDX_YEAR]),
        .last_o(last_day));
    tk_bcd_wrap #(.LOW(8'h01)) u_date (.val_i(reg_q[IDX_DATE]), .top_i(last_day),
        .inc_i(c_day), .val_o(date_n), .carry_o(c_date));
    tk_bcd_wrap #(.LOW(8'h01)) u_mon (.val_i(reg_q[IDX_MONTH]), .top_i(8'h12),
        .inc_i(c_date), .val_o(mon_n), .carry_o(c_mon));

    always_comb begin
        year_n = reg_q[IDX_YEAR];
        if (c_mon) year_n = (reg_q[IDX_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(reg_q[IDX_YEAR]);
        dow_n = reg_q[IDX_WDAY][2:0];
        if (c_day) dow_n = (reg_q[IDX_WDAY][2:0] >= 3'd7) ? 3'd1 : reg_q[IDX_WDAY][2:0] + 3'd1;
    end

    always_comb begin
        reg_d[IDX_CENTI] = cen_n;
        reg_d[IDX_SEC]   = sec_n;
        reg_d[IDX_MIN]   = min_n;
        reg_d[IDX_HOUR]  = hour_n;
        reg_d[IDX_WDAY]  = {2'b00, reg_q[IDX_WDAY][5:4], 1'b0, dow_n};
        reg_d[IDX_DATE]  = date_n;
        reg_d[IDX_MONTH] = mon_n;
        reg_d[IDX_YEAR]  = year_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                reg_q[i] <= reset_val(i);
            else if (wr_en_i && (wr_idx_i == i[IDX_W-1:0]))
                reg_q[i] <= wr_data_i & keep_mask(i);
            else
                reg_q[i] <= reg_d[i];
        end
    end

    // R2: units of hundredths step by one on a counted tick below 9
    assert_centi_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && reg_q[IDX_CENTI][3:0] < 4'd9) |=>
        reg_q[IDX_CENTI][3:0] == $past(reg_q[IDX_CENTI][3:0]) + 4'd1);

    // R3: 23:59:59.99 in 24-hour mode rolls the hour to 00
    assert_midnight24_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && reg_q[IDX_CENTI] == 8'h99 && reg_q[IDX_SEC] == 8'h59 &&
         reg_q[IDX_MIN] == 8'h59 && reg_q[IDX_HOUR] == 8'h23) |=> reg_q[IDX_HOUR] == 8'h00);

    // R4: 11 -> 12 in 12-hour mode flips the afternoon flag
    assert_pm_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_min && reg_q[IDX_HOUR][HOUR_MODE_BIT] && reg_q[IDX_HOUR][4:0] == 5'h11) |=>
        reg_q[IDX_HOUR][HOUR_PM_BIT] != $past(reg_q[IDX_HOUR][HOUR_PM_BIT]));

    // R7: a stopped timebase holds every register absent a write
    assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run_o && !wr_en_i) |=> $stable(reg_q));

    // R10: a load of hundredths wins over a simultaneous tick
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 3'd0) |=> reg_q[IDX_CENTI] == $past(wr_data_i));
endmodule

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
module sim_bcd_timekeeper;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_idx = '0, rd_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic osc_run, abort_allow;
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] m [8];

    always #2 clk = ~clk;

    bcd_timekeeper u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_idx_i(wr_idx), .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .osc_run_o(osc_run), .abort_allow_o(abort_allow));

    function automatic int dec(input logic [7:0] b); return (b >> 4) * 10 + (b & 8'h0F); endfunction
    function automatic logic [7:0] enc(input int n); return 8'((n / 10) * 16 + (n % 10)); endfunction
    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic logic [7:0] field_mask(input int i); // masks from R9
        case (i)
            1, 2: return 8'h7F;
            3: return 8'hBF;
            4: return 8'h37;
            5: return 8'h3F;
            6: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_tick();
        int c, s, mi, h, pm, dw, d, mo, y;
        bit cy;
        if (m[4][5]) return;                        // R7 stopped
        c = dec(m[0]) + 1; cy = (c == 100); if (cy) c = 0; m[0] = enc(c);
        if (!cy) return;
        s = dec(m[1]) + 1; cy = (s == 60); if (cy) s = 0; m[1] = enc(s);
        if (!cy) return;
        mi = dec(m[2]) + 1; cy = (mi == 60); if (cy) mi = 0; m[2] = enc(mi);
        if (!cy) return;
        cy = 0;
        if (m[3][7]) begin
            pm = m[3][5]; h = dec(m[3] & 8'h1F);
            if (h == 11) begin h = 12; cy = (pm == 1); pm = 1 - pm; end
            else if (h == 12) h = 1;
            else h++;
            m[3] = 8'h80 | 8'(pm << 5) | enc(h);
        end else begin
            h = dec(m[3] & 8'h3F);
            if (h == 23) begin h = 0; cy = 1; end else h++;
            m[3] = enc(h);
        end
        if (!cy) return;
        dw = m[4] & 7; dw = (dw == 7) ? 1 : dw + 1; m[4] = (m[4] & 8'h30) | 8'(dw);
        mo = dec(m[6]); y = dec(m[7]); d = dec(m[5]);
        if (d == mdays(mo, y)) begin
            m[5] = 8'h01;
            if (mo == 12) begin m[6] = 8'h01; m[7] = enc((y + 1) % 100); end
            else m[6] = enc(mo + 1);
        end else m[5] = enc(d + 1);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h00;
            m[4] = 8'h31; m[5] = 8'h01; m[6] = 8'h01; m[7] = 8'h00;
        end else if (wr_en) m[wr_idx] = wr_data & field_mask(int'(wr_idx));  // R10 load wins
        else if (tick) model_tick();
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd_chk(input int i, input logic [7:0] exp, input string tag);
        rd_idx = 3'(i); #0.1; chk(rd_data, exp, tag);
    endtask

    task automatic check_all();
        for (int i = 0; i < 8; i++)
            rd_chk(i, m[i], (i < 3) ? "R2 reg" : (i == 3) ? "R3/R4 hour" : (i == 4) ? "R5 wday" : "R6 date");
        chk({7'd0, osc_run}, {7'd0, ~m[4][5]}, "R7 osc_run");
        chk({7'd0, abort_allow}, {7'd0, ~m[4][4]}, "R8 abort_allow");
    endtask

    task automatic step(input bit t, input bit w, input int i, input logic [7:0] d);
        tick = t; wr_en = w; wr_idx = 3'(i); wr_data = d;
        @(negedge clk);
        tick = 0; wr_en = 0;
        check_all();
    endtask

    task automatic ticks(input int n); for (int k = 0; k < n; k++) step(1, 0, 0, 8'h00); endtask

    task automatic set_eve(input logic [7:0] hr, input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
        step(0, 1, 0, 8'h99); step(0, 1, 1, 8'h59); step(0, 1, 2, 8'h59);
        step(0, 1, 3, hr); step(0, 1, 5, dt); step(0, 1, 6, mo); step(0, 1, 7, yr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_chk(0, 8'h00, "R1"); rd_chk(3, 8'h00, "R1"); rd_chk(4, 8'h31, "R1");
        rd_chk(5, 8'h01, "R1"); rd_chk(6, 8'h01, "R1"); rd_chk(7, 8'h00, "R1");
        // R7 stopped timebase ignores ticks
        ticks(5);
        rd_chk(0, 8'h00, "R7 stopped");
        step(0, 1, 4, 8'h05);                       // run, abort allowed, weekday 5
        chk({7'd0, abort_allow}, 8'h01, "R8");
        ticks(250);                                 // R2
        rd_chk(1, 8'h02, "R2 seconds");
        // R3/R6 non-leap February, weekday 7 -> 1
        step(0, 1, 4, 8'h07);
        set_eve(8'h23, 8'h28, 8'h02, 8'h23); ticks(2);
        rd_chk(5, 8'h01, "R6 feb28"); rd_chk(6, 8'h03, "R6 march"); rd_chk(4, 8'h01, "R5 wrap");
        // R6 leap year 24, then 29 -> March
        set_eve(8'h23, 8'h28, 8'h02, 8'h24); ticks(1); rd_chk(5, 8'h29, "R6 leap24");
        set_eve(8'h23, 8'h29, 8'h02, 8'h24); ticks(1); rd_chk(6, 8'h03, "R6 leap end");
        set_eve(8'h23, 8'h28, 8'h02, 8'h00); ticks(1); rd_chk(5, 8'h29, "R6 year00");
        set_eve(8'h23, 8'h28, 8'h02, 8'h90); ticks(1); rd_chk(5, 8'h01, "R6 year90");
        set_eve(8'h23, 8'h30, 8'h04, 8'h10); ticks(1); rd_chk(6, 8'h05, "R6 april");
        set_eve(8'h23, 8'h31, 8'h12, 8'h99); ticks(1);
        rd_chk(7, 8'h00, "R6 year wrap"); rd_chk(6, 8'h01, "R6 month wrap");
        // R4 12-hour mode
        set_eve(8'h91, 8'h10, 8'h06, 8'h05); ticks(1); rd_chk(3, 8'hB2, "R4 noon");
        set_eve(8'hB2, 8'h10, 8'h06, 8'h05); ticks(1); rd_chk(3, 8'hA1, "R4 12->1");
        set_eve(8'hB1, 8'h10, 8'h06, 8'h05); ticks(1);
        rd_chk(3, 8'h92, "R4 midnight"); rd_chk(5, 8'h11, "R4 day advance");
        ticks(3000);
        // R10 write during tick drops the tick everywhere
        step(0, 1, 0, 8'h99);
        step(1, 1, 2, 8'h30);
        rd_chk(0, 8'h99, "R10 tick dropped"); rd_chk(2, 8'h30, "R10 loaded");
        ticks(1); rd_chk(0, 8'h00, "R10 resume");
        // R8 abort mask
        step(0, 1, 4, 8'h13);
        chk({7'd0, abort_allow}, 8'h00, "R8");
        // R9 dropped bits
        for (int i = 1; i < 7; i++) begin
            step(0, 1, i, 8'hFF);
            rd_chk(i, field_mask(i), "R9");
        end
        ticks(4);                                   // stopped by 0x37: R7
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule